// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the serial clock of an I2C master from the peripheral clock. It drives an open-drain pull-low enable for the SCL pad and reads the SCL line back through `scl_in`. The low and high phases are whole multiples of one programmed unit count. Standard mode uses a 1:1 ratio. Fast mode uses either 2:1 or 16:9, picked by a duty select. Standard mode serves bus rates up to 100 kHz, and fast mode serves rates above that up to 400 kHz. A separate rise allowance gives the number of cycles that SCL may take to rise, plus one. Rise cycles within that allowance are taken off the high phase, so a slow edge does not stretch the period. Any further wait is clock stretching by a device on the bus.

A byte engine next to this block uses two one-cycle strobes. `sda_sample_stb` marks the middle of each high phase, where SDA is read. `sda_change_stb` marks the first cycle of each low phase, where SDA may change. The timing inputs are captured only while `enable` is low.

The controller has four states. In IDLE the line is released. LOW pulls SCL down for the low length. RISE releases SCL and waits for the line to be seen high. HIGH times the rest of the high length. The transitions are:
- IDLE to LOW when enabled.
- LOW to RISE when the low count ends.
- RISE to HIGH when `scl_in` is seen high.
- HIGH to LOW when the high count ends.
- Any state to IDLE when `enable` is low.

Top module: `i2c_scl_clkgen`

## Requirements
- R1: Standard mode (`fast_sel`=0) gives a low phase and a high length of c cycles each, where c is `period_unit`, or 4 if `period_unit` is below 4.
- R2: Fast mode with `wide_duty_sel`=0 gives a low phase of 2c and a high length of c, where c is `period_unit`, or 1 if `period_unit` is 0.
- R3: Fast mode with `wide_duty_sel`=1 gives a low phase of 16c and a high length of 9c, with c clamped as in R2.
- R4: `wide_duty_sel` has no effect when `fast_sel`=0.
- R5: Let d be the number of cycles after release before `scl_in` reads high. Let a be `rise_allow`−1, or 0 if `rise_allow` is 0. Let H be the high length. SCL then stays released for d+1+H−min(d, a, H−1) cycles. While `scl_in` stays low the block waits in RISE without limit, which is clock stretching.
- R6: One cycle after `enable` is seen low, SCL is released, both strobes are 0 and the controller is in IDLE. After `enable` rises, the first low phase starts on the next clock edge and is full length.
- R7: `sda_sample_stb` pulses exactly once in each high phase. It never pulses while SCL is pulled low.
- R8: `sda_change_stb` pulses exactly once in each low phase, on its first cycle, and never while SCL is released.
- R9: The timing inputs are captured only while `enable` is low. Changes made while enabled take effect at the next enable.
- R10: During reset and afterwards with `enable` low, SCL is released and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the clock when high; idles the block and opens configuration capture when low |
| period_unit | input | UNIT_W | Unit count for the phase lengths |
| fast_sel | input | 1 | 1 selects fast mode, 0 selects standard mode |
| wide_duty_sel | input | 1 | In fast mode, 1 selects 16:9 and 0 selects 2:1 |
| rise_allow | input | RISE_W | Allowed SCL rise time in cycles, plus one |
| scl_in | input | 1 | Sampled SCL line level |
| scl_pull_en | output | 1 | 1 pulls SCL low (open drain) |
| sda_sample_stb | output | 1 | One-cycle strobe in the middle of the high phase |
| sda_change_stb | output | 1 | One-cycle strobe on the first cycle of the low phase |

## Verification
A wrong phase counter or length decode shows up directly as a wrong SCL pull-low run or released run. It is visible as soon as the first low phase after enable ends, so the bench compares every run length against a scoreboard. A stuck or wrongly cleared strobe-done flag shows within one high phase as a missing or doubled sample strobe. A bad rise credit shows in the released length of the first period run with a slow or stretched edge. Configuration captured at the wrong time shows as periods that change in the middle of an enabled run.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_RISE = 2'd2,
        PH_HIGH = 2'd3
    } scl_phase_e;

endpackage

// File: rtl/scl_cfg_latch.sv
module scl_cfg_latch #(
    parameter int UNIT_W = 12,
    parameter int RISE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [UNIT_W-1:0] unit_in,
    input  logic              fast_in,
    input  logic              wide_in,
    input  logic [RISE_W-1:0] rise_in,
    output logic [UNIT_W-1:0] unit_q,
    output logic              fast_q,
    output logic              wide_q,
    output logic [RISE_W-1:0] rise_q
);

    // Capture window is open only while the generator is idle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unit_q <= '0;
            fast_q <= 1'b0;
            wide_q <= 1'b0;
            rise_q <= '0;
        end else if (!enable) begin
            unit_q <= unit_in;
            fast_q <= fast_in;
            wide_q <= wide_in;
            rise_q <= rise_in;
        end
    end

    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable)) |->
            ($stable(unit_q) && $stable(fast_q) && $stable(wide_q) && $stable(rise_q)))
        else $error("configuration moved while enabled");

endmodule

// File: rtl/scl_len_calc.sv
module scl_len_calc #(
    parameter int UNIT_W = 12,
    parameter int RISE_W = 6,
    parameter int LEN_W  = UNIT_W + 5
) (
    input  logic [UNIT_W-1:0] unit_q,
    input  logic              fast_q,
    input  logic              wide_q,
    input  logic [RISE_W-1:0] rise_q,
    output logic [LEN_W-1:0]  low_len,
    output logic [LEN_W-1:0]  high_len,
    output logic [RISE_W-1:0] rise_cap
);

    localparam logic [UNIT_W-1:0] STD_FLOOR  = UNIT_W'(4);
    localparam logic [UNIT_W-1:0] FAST_FLOOR = UNIT_W'(1);

    logic [UNIT_W-1:0] unit_eff;
    logic [LEN_W-1:0]  unit_ext;

    always_comb begin
        if (fast_q) begin
            unit_eff = (unit_q < FAST_FLOOR) ? FAST_FLOOR : unit_q;
        end else begin
            unit_eff = (unit_q < STD_FLOOR) ? STD_FLOOR : unit_q;
        end
        unit_ext = LEN_W'(unit_eff);

        if (!fast_q) begin
            low_len  = unit_ext;
            high_len = unit_ext;
        end else if (wide_q) begin
            low_len  = unit_ext << 4;
            high_len = (unit_ext << 3) + unit_ext;
        end else begin
            low_len  = unit_ext << 1;
            high_len = unit_ext;
        end

        // Programmed value is the rise time plus one.
        rise_cap = (rise_q == '0) ? '0 : rise_q - 1'b1;
    end

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_gen_pkg::*;
#(
    parameter int LEN_W  = 17,
    parameter int RISE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              scl_in,
    input  logic [LEN_W-1:0]  low_len,
    input  logic [LEN_W-1:0]  high_len,
    input  logic [RISE_W-1:0] rise_cap,
    output logic              scl_pull,
    output logic              smp_stb,
    output logic              chg_stb
);

    scl_phase_e        state_q, state_d;
    logic [LEN_W-1:0]  cnt_q, cnt_d;
    logic [RISE_W-1:0] rcnt_q, rcnt_d;
    logic              done_q, done_d;

    logic [LEN_W-1:0]  high_last;
    logic [LEN_W-1:0]  rise_ext;
    logic [LEN_W-1:0]  credit;
    logic [LEN_W-1:0]  mid_pt;

    assign high_last = high_len - 1'b1;
    assign rise_ext  = LEN_W'(rcnt_q);
    assign credit    = (rise_ext > high_last) ? high_last : rise_ext;
    assign mid_pt    = high_len >> 1;

    // Outputs decoded from the registered phase.
    always_comb begin
        scl_pull = (state_q == PH_LOW);
        chg_stb  = (state_q == PH_LOW) && (cnt_q == '0);
        smp_stb  = (state_q == PH_HIGH) && (cnt_q >= mid_pt) && !done_q;
    end

    // Next-phase logic.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        rcnt_d  = rcnt_q;
        done_d  = done_q;
        if (!enable) begin
            state_d = PH_IDLE;
            cnt_d   = '0;
            rcnt_d  = '0;
            done_d  = 1'b0;
        end else begin
            unique case (state_q)
                PH_IDLE: begin
                    state_d = PH_LOW;
                    cnt_d   = '0;
                end
                PH_LOW: begin
                    if (cnt_q == low_len - 1'b1) begin
                        state_d = PH_RISE;
                        cnt_d   = '0;
                        rcnt_d  = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                PH_RISE: begin
                    if (scl_in) begin
                        state_d = PH_HIGH;
                        cnt_d   = credit;
                        done_d  = 1'b0;
                    end else if (rcnt_q != rise_cap) begin
                        rcnt_d = rcnt_q + 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (smp_stb) begin
                        done_d = 1'b1;
                    end
                    if (cnt_q == high_last) begin
                        state_d = PH_LOW;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: state_d = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
            rcnt_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            rcnt_q  <= rcnt_d;
            done_q  <= done_d;
        end
    end

    p_idle_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!scl_pull && !smp_stb && !chg_stb))
        else $error("not idle after disable");

    p_chg_at_low_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull) |-> chg_stb)
        else $error("low phase began without change strobe");

    p_smp_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |=> !smp_stb)
        else $error("sample strobe wider than one cycle");

    p_smp_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |-> !scl_pull)
        else $error("sample strobe while SCL pulled");

    p_stretch_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_q == PH_RISE && !scl_in) |=>
            (state_q == PH_RISE || state_q == PH_IDLE))
        else $error("high phase started with SCL low");

endmodule

// File: rtl/i2c_scl_clkgen.sv
module i2c_scl_clkgen #(
    parameter int UNIT_W = 12,
    parameter int RISE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [UNIT_W-1:0] period_unit,
    input  logic              fast_sel,
    input  logic              wide_duty_sel,
    input  logic [RISE_W-1:0] rise_allow,
    input  logic              scl_in,
    output logic              scl_pull_en,
    output logic              sda_sample_stb,
    output logic              sda_change_stb
);

    localparam int LEN_W = UNIT_W + 5;

    logic [UNIT_W-1:0] unit_q;
    logic              fast_q;
    logic              wide_q;
    logic [RISE_W-1:0] rise_q;
    logic [LEN_W-1:0]  low_len;
    logic [LEN_W-1:0]  high_len;
    logic [RISE_W-1:0] rise_cap;

    scl_cfg_latch #(.UNIT_W(UNIT_W), .RISE_W(RISE_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .unit_in (period_unit),
        .fast_in (fast_sel),
        .wide_in (wide_duty_sel),
        .rise_in (rise_allow),
        .unit_q  (unit_q),
        .fast_q  (fast_q),
        .wide_q  (wide_q),
        .rise_q  (rise_q)
    );

    scl_len_calc #(.UNIT_W(UNIT_W), .RISE_W(RISE_W), .LEN_W(LEN_W)) u_calc (
        .unit_q   (unit_q),
        .fast_q   (fast_q),
        .wide_q   (wide_q),
        .rise_q   (rise_q),
        .low_len  (low_len),
        .high_len (high_len),
        .rise_cap (rise_cap)
    );

    scl_phase_fsm #(.LEN_W(LEN_W), .RISE_W(RISE_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .scl_in   (scl_in),
        .low_len  (low_len),
        .high_len (high_len),
        .rise_cap (rise_cap),
        .scl_pull (scl_pull_en),
        .smp_stb  (sda_sample_stb),
        .chg_stb  (sda_change_stb)
    );

endmodule

// File: tb/i2c_scl_clkgen_tb.sv
module i2c_scl_clkgen_tb;

    localparam int UW = 12;
    localparam int RW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic [UW-1:0] unit = '0;
    logic          fast = 1'b0;
    logic          wide = 1'b0;
    logic [RW-1:0] rallow = '0;
    logic          scl_in;
    logic          pull;
    logic          smp;
    logic          chg;

    always #5 clk = ~clk;

    i2c_scl_clkgen #(.UNIT_W(UW), .RISE_W(RW)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .enable         (en),
        .period_unit    (unit),
        .fast_sel       (fast),
        .wide_duty_sel  (wide),
        .rise_allow     (rallow),
        .scl_in         (scl_in),
        .scl_pull_en    (pull),
        .sda_sample_stb (smp),
        .sda_change_stb (chg)
    );

    // Bus model: line rises rise_dly cycles after release.
    int rel_cnt  = 0;
    int rise_dly = 0;
    always @(posedge clk) begin
        if (pull) rel_cnt <= 0;
        else if (rel_cnt < 1000) rel_cnt <= rel_cnt + 1;
    end
    assign scl_in = !pull && (rel_cnt >= rise_dly);

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Scoreboard: expected run kind (1 = pulled low), length, requirement.
    bit    q_low[$];
    int    q_len[$];
    string q_req[$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run(input bit kind, input int len, input int ns, input int nc);
        bit    ek;
        int    el;
        string er;
        if (q_len.size() > 0) begin
            ek = q_low.pop_front();
            el = q_len.pop_front();
            er = q_req.pop_front();
            check(kind == ek, er, "run kind", int'(kind), int'(ek));
            check(len == el, er, kind ? "low run length" : "released run length", len, el);
            check(ns == (kind ? 0 : 1), "R7", "sample strobes in run", ns, kind ? 0 : 1);
            check(nc == (kind ? 1 : 0), "R8", "change strobes in run", nc, kind ? 1 : 0);
        end
    endtask

    // Monitor: measures pull-low and released runs while enabled.
    bit armed = 1'b0;
    bit prev  = 1'b0;
    int run   = 0;
    int smp_n = 0;
    int chg_n = 0;
    always @(negedge clk) begin
        if (!rst_n || !en) begin
            armed = 1'b0;
        end else if (!armed) begin
            if (pull) begin
                armed = 1'b1;
                prev  = 1'b1;
                run   = 1;
                smp_n = 0;
                chg_n = chg ? 1 : 0;
            end
        end else begin
            if (pull == prev) begin
                run++;
            end else begin
                finish_run(prev, run, smp_n, chg_n);
                prev  = pull;
                run   = 1;
                smp_n = 0;
                chg_n = 0;
            end
            if (smp) smp_n++;
            if (chg) chg_n++;
        end
    end

    task automatic run_case(input bit f, input bit d, input int u, input int ra,
                            input int rd, input int lo, input int rel,
                            input string req, input bit mid_change, input int new_u);
        int t;
        unit     = UW'(u);
        fast     = f;
        wide     = d;
        rallow   = RW'(ra);
        rise_dly = rd;
        repeat (3) @(posedge clk);
        #1;
        for (int i = 0; i < 3; i++) begin
            q_low.push_back(1'b1); q_len.push_back(lo);  q_req.push_back(req);
            q_low.push_back(1'b0); q_len.push_back(rel); q_req.push_back(req);
        end
        en = 1'b1;
        if (mid_change) begin
            repeat (3) @(posedge clk);
            #1;
            unit = UW'(new_u);
            fast = !f;
            wide = !d;
        end
        t = 0;
        while (q_len.size() > 0 && t < 20000) begin
            @(posedge clk);
            t++;
        end
        #1;
        if (q_len.size() > 0) begin
            check(1'b0, req, "runs left unseen", q_len.size(), 0);
            q_low.delete(); q_len.delete(); q_req.delete();
        end
        en = 1'b0;
        repeat (3) @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        check(1'b0, "ALL", "watchdog expired", cycles, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        // R10: reset state
        repeat (2) @(negedge clk);
        check(pull == 1'b0, "R10", "pull in reset", int'(pull), 0);
        check(smp == 1'b0 && chg == 1'b0, "R10", "strobes in reset", int'(smp | chg), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(pull == 1'b0, "R10", "pull after reset, disabled", int'(pull), 0);
        check(smp == 1'b0 && chg == 1'b0, "R10", "strobes after reset", int'(smp | chg), 0);
        @(posedge clk); #1;

        // R1: standard mode, 1:1, floor of 4
        run_case(1'b0, 1'b0, 5, 3, 0, 5, 6, "R1", 1'b0, 0);
        run_case(1'b0, 1'b0, 2, 3, 0, 4, 5, "R1", 1'b0, 0);
        run_case(1'b0, 1'b0, 0, 3, 0, 4, 5, "R1", 1'b0, 0);
        // R4: duty select ignored in standard mode
        run_case(1'b0, 1'b1, 5, 3, 0, 5, 6, "R4", 1'b0, 0);
        // R2: fast 2:1, floor of 1
        run_case(1'b1, 1'b0, 3, 3, 0, 6, 4, "R2", 1'b0, 0);
        run_case(1'b1, 1'b0, 0, 3, 0, 2, 2, "R2", 1'b0, 0);
        // R3: fast 16:9
        run_case(1'b1, 1'b1, 1, 3, 0, 16, 10, "R3", 1'b0, 0);
        run_case(1'b1, 1'b1, 2, 4, 1, 32, 19, "R3", 1'b0, 0);
        // R5: rise credit and stretching
        run_case(1'b0, 1'b0, 6, 4, 2, 6, 7, "R5", 1'b0, 0);
        run_case(1'b0, 1'b0, 6, 4, 6, 6, 10, "R5", 1'b0, 0);
        run_case(1'b0, 1'b0, 6, 0, 2, 6, 9, "R5", 1'b0, 0);
        run_case(1'b1, 1'b0, 2, 10, 5, 4, 7, "R5", 1'b0, 0);
        // R9: changes while enabled are held off until next enable
        run_case(1'b0, 1'b0, 5, 3, 0, 5, 6, "R9", 1'b1, 9);
        run_case(1'b0, 1'b0, 9, 3, 0, 9, 10, "R9", 1'b0, 0);

        // R6: disable in the middle of a low phase
        unit = UW'(20); fast = 1'b0; wide = 1'b0; rise_dly = 0;
        repeat (2) @(posedge clk); #1;
        en = 1'b1;
        repeat (5) @(posedge clk); #1;
        check(pull == 1'b1, "R6", "pulled low while running", int'(pull), 1);
        en = 1'b0;
        @(posedge clk); @(negedge clk);
        check(pull == 1'b0, "R6", "pull one cycle after disable", int'(pull), 0);
        check(smp == 1'b0 && chg == 1'b0, "R6", "strobes after disable", int'(smp | chg), 0);
        repeat (4) @(negedge clk);
        check(pull == 1'b0, "R6", "pull stays released", int'(pull), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule